// File: doc/BRIEF.md
# Weight-Stationary Systolic Multiply-Accumulate Grid

This block is a square grid of N x N multiply-accumulate cells that computes the product of a stored weight matrix and a stream of input vectors. Before computing, the weights are written into the cells, one row per cycle. Each cell keeps its weight for as long as computing goes on. A matrix-matrix product is formed by presenting the columns of the second matrix as a sequence of input vectors.

Each input vector enters at the left edge. Element r feeds every cell of row r, after a delay of r cycles that lines it up with the partial sums moving down. Each cell multiplies its weight by its row input and adds the product to the registered partial sum from the cell above. The finished sum for every column leaves the bottom edge with its own valid flag. Vectors may arrive back to back or with gaps. A weight write is refused while any vector is still being computed.

Top module: `ws_mac_grid`

## Requirements
- R1: Reset (`rst_n` low, asynchronous) clears every stored weight, every partial sum and every valid flag, so `y_valid` and `y_data` read as all zeros. A vector sent after reset, with no load, gives all-zero sums.
- R2: A write with `wt_we` high and `wt_row` = r, when accepted, stores `wt_data[c*DW +: DW]` as the weight of row r, column c. A vector with a 1 in element r and 0 elsewhere then returns row r of the weights as the column sums.
- R3: For a vector x, where element r is `x_data[r*DW +: DW]`, column c gives the sum over r of w[r][c]*x[r] on `y_data[c*SW +: SW]`. Weights and inputs are signed two's complement.
- R4: A vector sampled at clock edge k produces its sums and `y_valid` right after edge k+N, high for exactly one cycle. Every accepted vector produces exactly one result.
- R5: Vectors sent on consecutive cycles, or separated by idle cycles, each produce their own result in the same order and with the same spacing. The weights stay in use for every vector.
- R6: All bits of `y_valid` are high together or low together.
- R7: A weight write is ignored if `x_valid` is high in the same cycle, or if a vector already sampled has not yet shown its result at the bottom edge. A write in the cycle after that result appears is accepted.
- R8: Weight writes never raise `y_valid`. `y_valid` is high only for results of sampled vectors.
- R9: Column sums wrap modulo 2^SW, with no saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wt_we | input | 1 | Weight row write request |
| wt_row | input | max(1,clog2(N)) | Row index of the weight write |
| wt_data | input | N*DW | Weights of one row, column c in bits c*DW |
| x_valid | input | 1 | An input vector is present this cycle |
| x_data | input | N*DW | Input vector, element r in bits r*DW |
| y_valid | output | N | Per-column result valid |
| y_data | output | N*SW | Column sums, column c in bits c*SW |

## Verification
A weight write can fall in the same cycle as a vector entering, or in any cycle while that vector is still moving down the grid. The bench raises `wt_we` together with `x_valid`, again on every cycle until the result shows, and then on the first cycle after it. The in-flight result must match the old weights. Unit vectors then read the rows back: the refused rows must be unchanged, and the row written at the boundary must hold its new values.

// File: rtl/ws_mac_grid.sv
`timescale 1ns/1ps
module ws_mac_grid #(
  parameter int N  = 4,
  parameter int DW = 8,
  parameter int SW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wt_we,
  input  logic [((N>1)?$clog2(N):1)-1:0] wt_row,
  input  logic [N*DW-1:0]      wt_data,
  input  logic                 x_valid,
  input  logic [N*DW-1:0]      x_data,
  output logic [N-1:0]         y_valid,
  output logic [N*SW-1:0]      y_data
);
  localparam int RW = (N > 1) ? $clog2(N) : 1;
  localparam int PW = 2 * DW;
  localparam int CW = $clog2(N + 3);

  logic signed [DW-1:0] wgt  [N][N];
  logic signed [DW-1:0] xsk  [N][N];
  logic signed [SW-1:0] psum [N][N];
  logic signed [SW-1:0] prd  [N][N];
  logic                 vld  [N][N];
  logic                 vin;
  logic                 busy;
  logic                 wr_ok;

  function automatic logic signed [SW-1:0] mul_ext(input logic signed [DW-1:0] a,
                                                   input logic signed [DW-1:0] b);
    logic signed [PW-1:0] p;
    p = PW'(a) * PW'(b);
    return SW'(p);
  endfunction

  always_comb begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        prd[r][c] = mul_ext(wgt[r][c], xsk[r][r]);
  end

  always_comb begin
    busy = x_valid | vin;
    for (int r = 0; r < N - 1; r++)
      busy = busy | vld[r][0];
  end

  assign wr_ok = wt_we & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vin <= 1'b0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          wgt[r][c]  <= '0;
          xsk[r][c]  <= '0;
          psum[r][c] <= '0;
          vld[r][c]  <= 1'b0;
        end
    end else begin
      vin <= x_valid;
      for (int r = 0; r < N; r++) begin
        xsk[r][0] <= x_data[r*DW +: DW];
        for (int d = 1; d < N; d++)
          xsk[r][d] <= xsk[r][d-1];
        for (int c = 0; c < N; c++)
          if (wr_ok && wt_row == RW'(r))
            wgt[r][c] <= wt_data[c*DW +: DW];
      end
      for (int c = 0; c < N; c++) begin
        psum[0][c] <= prd[0][c];
        vld[0][c]  <= vin;
      end
      for (int r = 1; r < N; r++)
        for (int c = 0; c < N; c++) begin
          psum[r][c] <= psum[r-1][c] + prd[r][c];
          vld[r][c]  <= vld[r-1][c];
        end
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_out
    assign y_valid[c]          = vld[N-1][c];
    assign y_data[c*SW +: SW]  = psum[N-1][c];
  end

  logic [N*N*DW-1:0] wflat;
  always_comb begin
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        wflat[(r*N+c)*DW +: DW] = wgt[r][c];
  end

  logic [CW-1:0] inflight;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else if (x_valid && !y_valid[0]) inflight <= inflight + CW'(1);
    else if (!x_valid && y_valid[0]) inflight <= inflight - CW'(1);
  end

  AST_WEIGHTS_HELD: assert property (@(posedge clk) disable iff (!rst_n) busy |=> $stable(wflat)); // R7
  AST_COLS_AGREE: assert property (@(posedge clk) disable iff (!rst_n) (y_valid == '0) || (y_valid == '1)); // R6
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) y_valid[0] |-> inflight != '0); // R8
  AST_DEPTH_BOUND: assert property (@(posedge clk) disable iff (!rst_n) inflight <= CW'(N + 1)); // R4
endmodule

// File: tb/test_ws_mac_grid.sv
`timescale 1ns/1ps
module test_ws_mac_grid;
  localparam int N = 4, DW = 8, SW = 16, RW = 2, NV = 10;
  localparam logic [N*DW-1:0] XTAB [NV] = '{
    32'h00000001, 32'h00000100, 32'h00010000, 32'h01000000,
    32'h05FD0A02, 32'h80808080, 32'h7F7F7F7F, 32'h00000000,
    32'hFF01FF01, 32'h10E020F0};
  // unit vectors read rows back (R2); the rest check the sums (R3)
  localparam int TTAB [NV] = '{2, 2, 2, 2, 3, 3, 3, 3, 3, 3};

  logic clk = 0, rst_n = 0, wt_we = 0, x_valid = 0;
  logic [RW-1:0] wt_row = '0;
  logic [N*DW-1:0] wt_data = '0, x_data = '0;
  logic [N-1:0] y_valid;
  logic [N*SW-1:0] y_data;

  int tests = 0, fails = 0, cyc = 0;
  int wm [N][N];
  logic [N*SW-1:0] q_exp [64];
  int q_cyc [64];
  int q_tag [64];
  int qh = 0, qt = 0;
  bit mon_on = 0;

  ws_mac_grid #(.N(N), .DW(DW), .SW(SW)) i_ws_mac_grid (
    .clk(clk), .rst_n(rst_n), .wt_we(wt_we), .wt_row(wt_row), .wt_data(wt_data),
    .x_valid(x_valid), .x_data(x_data), .y_valid(y_valid), .y_data(y_data));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input int tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N*SW-1:0] expv(input logic [N*DW-1:0] x);
    logic [N*SW-1:0] e;
    for (int c = 0; c < N; c++) begin
      int s = 0;
      for (int r = 0; r < N; r++)
        s += wm[r][c] * int'($signed(x[r*DW +: DW]));
      e[c*SW +: SW] = s[SW-1:0];
    end
    return e;
  endfunction

  function automatic logic [N*DW-1:0] pack(input int v [N]);
    logic [N*DW-1:0] p;
    for (int c = 0; c < N; c++) p[c*DW +: DW] = v[c][DW-1:0];
    return p;
  endfunction

  task automatic push(input logic [N*DW-1:0] x, input int tag);
    q_exp[qt % 64] = expv(x);
    q_cyc[qt % 64] = cyc + 1;
    q_tag[qt % 64] = tag;
    qt++;
  endtask

  task automatic load_row(input int r, input int v [N]);
    @(negedge clk);
    wt_we = 1; wt_row = RW'(r); wt_data = pack(v);
    for (int c = 0; c < N; c++) wm[r][c] = v[c];
    @(posedge clk);
    @(negedge clk);
    wt_we = 0;
    check(y_valid == '0, 8, "y_valid during weight load", y_valid, 0); // R8
  endtask

  task automatic load_const(input int val);
    int v [N];
    for (int c = 0; c < N; c++) v[c] = val;
    for (int r = 0; r < N; r++) load_row(r, v);
  endtask

  task automatic send(input logic [N*DW-1:0] x, input int tag);
    @(negedge clk);
    x_valid = 1; x_data = x;
    push(x, tag);
    @(posedge clk);
  endtask

  task automatic drop();
    @(negedge clk);
    x_valid = 0; x_data = '0;
  endtask

  task automatic drain();
    repeat (N + 3) @(posedge clk);
    @(negedge clk);
    check(qh == qt, 4, "results outstanding", qt - qh, 0); // R4
  endtask

  always @(negedge clk) begin
    if (mon_on && y_valid != '0) begin
      check(y_valid == '1, 6, "columns valid together", y_valid, {N{1'b1}}); // R6
      if (qh == qt) check(0, 8, "unexpected y_valid", y_valid, 0); // R8
      else begin
        check(y_data == q_exp[qh % 64], q_tag[qh % 64], "column sums", y_data, q_exp[qh % 64]);
        check(cyc == q_cyc[qh % 64] + N, 4, "latency", cyc, q_cyc[qh % 64] + N); // R4
        qh++;
      end
    end
  end

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int v [N];
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(y_valid == '0 && y_data == '0, 1, "outputs in reset", {y_valid, y_data[59:0]}, 0); // R1
    rst_n = 1; mon_on = 1;

    // R2: load a signed weight pattern row by row
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) v[c] = (r * N + c) * 13 - 100;
      load_row(r, v);
    end

    // R3, R5: walk the table back to back
    for (int i = 0; i < NV; i++) send(XTAB[i], TTAB[i]);
    drop(); drain();

    // R5: vectors with idle gaps in between
    send(XTAB[4], 5); drop();
    send(XTAB[9], 5); send(XTAB[8], 5); drop();
    @(negedge clk); @(negedge clk);
    send(XTAB[6], 5); drop(); drain();

    // R7: write in the same cycle as x_valid, then every cycle while in flight
    @(negedge clk);
    x_valid = 1; x_data = XTAB[4]; push(XTAB[4], 7);
    wt_we = 1; wt_row = 0; wt_data = '1;
    @(posedge clk);
    for (int i = 1; i <= N; i++) begin
      @(negedge clk);
      x_valid = 0; x_data = '0;
      wt_we = 1; wt_row = RW'(i % N); wt_data = 32'h7F7F7F7F;
      @(posedge clk);
    end
    // R7: result is now out, this write must land
    @(negedge clk);
    for (int c = 0; c < N; c++) v[c] = 9 - 5 * c;
    wt_we = 1; wt_row = 2; wt_data = pack(v);
    for (int c = 0; c < N; c++) wm[2][c] = v[c];
    @(posedge clk);
    @(negedge clk);
    wt_we = 0;
    for (int i = 0; i < N; i++) send(XTAB[i], 7);
    drop(); drain();

    // R9: sums wrap modulo 2^SW
    load_const(-128);
    send(32'h80808080, 9); drop(); drain();
    load_const(127);
    send(32'h80808080, 9); send(32'h7F7F7F7F, 9); drop(); drain();

    // R1: reset mid-run clears results and weights
    send(XTAB[4], 1);
    @(negedge clk);
    x_valid = 0; mon_on = 0; rst_n = 0;
    #1;
    check(y_valid == '0 && y_data == '0, 1, "outputs after reset", {y_valid, y_data[59:0]}, 0); // R1
    qh = qt;
    for (int r = 0; r < N; r++) for (int c = 0; c < N; c++) wm[r][c] = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1; mon_on = 1;
    send(XTAB[6], 1); drop(); drain();

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule